// File: doc/BRIEF.md
# Stream-Mode Test Flit Ingress Buffer

This block connects a tester that streams test flits at a fixed rate to the injection port of an on-chip network. The tester cannot pause. The network port can stall for tens of cycles while a link retransmits. Every incoming flit goes into a small FIFO. The head of the FIFO is offered to the network with a valid/accept handshake.

The test stream is cut into segments. After each segment comes a short run of filler flits whose content does not matter, and each incoming flit carries a tag that marks it as filler. While a backlog exists, filler flits are thrown away instead of stored. This lets the buffer catch up after a stall without losing real test data.

The FIFO depth is a parameter. It should be at least the retransmission penalty multiplied by the injection rate: 10 flits for a 40-cycle penalty at one flit every 4 cycles. The block raises a sticky overflow flag if a data flit is lost. It also reports how many filler flits it has discarded and how many flits it currently holds.

Top module: `tstream_ingress`

## Requirements
- R1: After reset, out_valid, occupancy, drop_count and overflow are all 0. An asynchronous assertion of rst_n clears them at once. Release takes effect two clock edges after rst_n rises.
- R2: A flit that is written appears on out_data in arrival order. If the FIFO was empty, out_valid rises in the cycle after the clock edge that sampled the flit.
- R3: out_valid is 1 exactly when occupancy is nonzero. While out_valid is 1 and out_accept is 0, out_data holds its value. A flit leaves the FIFO only on a clock edge where out_valid and out_accept are both 1.
- R4: A filler flit (in_valid=1, in_filler=1) sampled while occupancy is nonzero is not stored. It increments drop_count by 1, and occupancy changes only by any pop on that edge. This also applies when the FIFO is full, and no overflow is raised in that case.
- R5: A filler flit sampled while occupancy is 0 is stored and forwarded like a data flit.
- R6: drop_count saturates at its all-ones value and stays there until reset.
- R7: A data flit (in_filler=0) sampled while occupancy equals DEPTH is lost, even if a pop happens on the same edge. It sets overflow, which stays 1 until reset.
- R8: occupancy equals the stored flits minus the popped flits. A write and a pop on the same edge leave it unchanged, and it never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Tester presents a flit this cycle |
| in_filler | input | 1 | 1 = don't-care filler flit, 0 = test data flit |
| in_data | input | FLIT_W | Incoming flit payload |
| out_valid | output | 1 | A flit is offered to the network |
| out_data | output | FLIT_W | Head-of-FIFO flit |
| out_accept | input | 1 | Network takes the offered flit this cycle |
| overflow | output | 1 | Sticky flag: a data flit was lost |
| drop_count | output | DROP_W | Saturating count of discarded filler flits |
| occupancy | output | clog2(DEPTH+1) | Flits currently held |

## Verification
The embedded assertions check the following on every cycle:
- the head flit stays stable under back-pressure;
- no write happens into a full FIFO and no pop from an empty one;
- overflow stays set, and it rises only after a data flit met a full FIFO;
- drop_count moves by exactly one step and stays at saturation;
- occupancy does not grow when a filler meets a backlog.

Only the bench scenarios can show that:
- data leaves in arrival order;
- the exact set of flits is discarded under mixed segment/filler traffic with 40-cycle stalls;
- overflow occurs only when a stall outlasts the buffer depth;
- drop_count saturates at its all-ones value (R6).

// File: rtl/tstream_pkg.sv
`timescale 1ns/1ps
package tstream_pkg;

  // Outcome for one tester flit slot
  typedef enum logic [1:0] {
    ADM_IDLE  = 2'd0,  // nothing arrived
    ADM_WRITE = 2'd1,  // store into the FIFO
    ADM_DROP  = 2'd2,  // filler discarded because a backlog exists
    ADM_LOST  = 2'd3   // data flit met a full FIFO
  } admit_e;

endpackage

// File: rtl/tstream_rst_sync.sv
`timescale 1ns/1ps
module tstream_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/tstream_admit.sv
`timescale 1ns/1ps
module tstream_admit
  import tstream_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             in_valid,
  input  logic             in_filler,
  input  logic [CNT_W-1:0] occ,
  output admit_e           decision
);

  logic backlog;
  logic full;

  assign backlog = (occ != '0);
  assign full    = (occ == CNT_W'(DEPTH));

  // Filler takes precedence: with any backlog it is discarded, so a full
  // FIFO never reports a lost filler.
  always_comb begin
    decision = ADM_IDLE;
    if (in_valid) begin
      if (in_filler && backlog) begin
        decision = ADM_DROP;
      end else if (full) begin
        decision = ADM_LOST;
      end else begin
        decision = ADM_WRITE;
      end
    end
  end

endmodule

// File: rtl/tstream_fifo.sv
`timescale 1ns/1ps
module tstream_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en) wr_ptr_d = ptr_next(wr_ptr_q);
    if (rd_en) rd_ptr_d = ptr_next(rd_ptr_q);
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage carries no reset; only the write enable gates it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data = mem[rd_ptr_q];
  assign count   = cnt_q;

  AST_FIFO_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CNT_W'(DEPTH)));  // R7
  AST_FIFO_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q != '0));  // R3
  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));  // R8

endmodule

// File: rtl/tstream_status.sv
`timescale 1ns/1ps
module tstream_status #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ovf,
  input  logic              drop_inc,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_count
);

  logic              ovf_q, ovf_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              drop_en;

  assign drop_en = drop_inc && (drop_q != '1);

  always_comb begin
    ovf_d  = ovf_q | set_ovf;
    drop_d = drop_q;
    if (drop_en) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      drop_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      drop_q <= drop_d;
    end
  end

  assign overflow   = ovf_q;
  assign drop_count = drop_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);  // R7
  AST_DROP_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q == '1) |=> (drop_q == '1));  // R6
  AST_DROP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + 1'b1));  // R4

endmodule

// File: rtl/tstream_ingress.sv
`timescale 1ns/1ps
module tstream_ingress
  import tstream_pkg::*;
#(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 10,
  parameter int DROP_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_filler,
  input  logic [FLIT_W-1:0] in_data,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_data,
  input  logic              out_accept,
  output logic              overflow,
  output logic [DROP_W-1:0] drop_count,
  output logic [CNT_W-1:0]  occupancy
);

  logic             rst_sn;
  admit_e           decision;
  logic             wr_en;
  logic             rd_en;
  logic [CNT_W-1:0] count;

  tstream_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  tstream_admit #(.DEPTH(DEPTH)) u_admit (
    .in_valid  (in_valid),
    .in_filler (in_filler),
    .occ       (count),
    .decision  (decision)
  );

  assign wr_en     = (decision == ADM_WRITE);
  assign out_valid = (count != '0);
  assign rd_en     = out_valid && out_accept;

  tstream_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_data (out_data),
    .count   (count)
  );

  tstream_status #(.DROP_W(DROP_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_sn),
    .set_ovf    (decision == ADM_LOST),
    .drop_inc   (decision == ADM_DROP),
    .overflow   (overflow),
    .drop_count (drop_count)
  );

  assign occupancy = count;

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_accept) |=> (out_valid && $stable(out_data)));  // R3
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(overflow) |-> $past(in_valid && !in_filler && (occupancy == CNT_W'(DEPTH))));  // R7
  AST_FILLER_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_filler && (occupancy != '0)) |=> (occupancy <= $past(occupancy)));  // R4
  AST_EMPTY_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && (occupancy == '0)) |=> out_valid);  // R5

endmodule

// File: tb/tstream_ingress_test.sv
`timescale 1ns/1ps
module tstream_ingress_test;

  localparam int W      = 32;
  localparam int DEPTH  = 10;
  localparam int DROP_W = 6;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int DROP_MAX = (1 << DROP_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_filler = 1'b0;
  logic [W-1:0]      in_data = '0;
  logic              out_accept = 1'b0;
  logic              out_valid;
  logic [W-1:0]      out_data;
  logic              overflow;
  logic [DROP_W-1:0] drop_count;
  logic [CNT_W-1:0]  occupancy;

  always #2.5 clk = ~clk;  // 200 MHz

  tstream_ingress #(.FLIT_W(W), .DEPTH(DEPTH), .DROP_W(DROP_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_filler  (in_filler),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_accept (out_accept),
    .overflow   (overflow),
    .drop_count (drop_count),
    .occupancy  (occupancy)
  );

  // Reference model state
  logic [W-1:0] mq[$];
  bit           m_ovf;
  int           m_drop;
  int           n_vec;
  int           n_fail;
  bit           done;

  function automatic int sat_inc(input int c);
    return (c >= DROP_MAX) ? DROP_MAX : c + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  task automatic compare_outputs();
    check(out_valid === (mq.size() != 0), "R3", "out_valid",
          longint'(out_valid), longint'(mq.size() != 0));
    if (mq.size() != 0)
      check(out_data === mq[0], "R2", "out_data order", longint'(out_data), longint'(mq[0]));
    check(int'(occupancy) == mq.size(), "R8", "occupancy",
          longint'(occupancy), longint'(mq.size()));
    check(int'(drop_count) == m_drop, "R4", "drop_count",
          longint'(drop_count), longint'(m_drop));
    check(overflow === m_ovf, "R7", "overflow", longint'(overflow), longint'(m_ovf));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit v, input bit f, input logic [W-1:0] d, input bit acc);
    int  occ;
    bit  pop, wr, drp, lost;
    compare_outputs();
    in_valid   = v;
    in_filler  = f;
    in_data    = d;
    out_accept = acc;
    occ  = mq.size();
    pop  = (occ > 0) && acc;
    wr   = 1'b0;
    drp  = 1'b0;
    lost = 1'b0;
    if (v) begin
      if (f && occ > 0)       drp  = 1'b1;
      else if (occ == DEPTH)  lost = 1'b1;
      else                    wr   = 1'b1;
    end
    @(posedge clk);
    if (pop)  void'(mq.pop_front());
    if (wr)   mq.push_back(d);
    if (drp)  m_drop = sat_inc(m_drop);
    if (lost) m_ovf = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_filler  = 1'b0;
    out_accept = 1'b0;
    mq.delete();
    m_ovf  = 1'b0;
    m_drop = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n, input bit acc);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, acc);
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    int seed_dummy;
    n_vec = 0; n_fail = 0; done = 1'b0;
    seed_dummy = $urandom(32'h5eed_2024);
    @(negedge clk);
    do_reset();

    // R1: reset values
    check(out_valid === 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(occupancy === '0, "R1", "occupancy after reset", longint'(occupancy), 0);
    check(drop_count === '0, "R1", "drop_count after reset", longint'(drop_count), 0);
    check(overflow === 1'b0, "R1", "overflow after reset", longint'(overflow), 0);

    // R2: three back-to-back data flits under stall, then drain in order
    step(1'b1, 1'b0, 32'hA000_0001, 1'b0);
    check(out_valid === 1'b1, "R2", "valid one cycle after first write", longint'(out_valid), 1);
    step(1'b1, 1'b0, 32'hA000_0002, 1'b0);
    step(1'b1, 1'b0, 32'hA000_0003, 1'b0);
    idle(3, 1'b0);
    check(out_data === 32'hA000_0001, "R3", "head held under stall", longint'(out_data), 32'hA000_0001);
    idle(4, 1'b1);

    // R5: filler into an empty FIFO is stored
    step(1'b1, 1'b1, 32'hF00D_0005, 1'b0);
    check(int'(occupancy) == 1, "R5", "filler stored when empty", longint'(occupancy), 1);
    check(out_data === 32'hF00D_0005, "R5", "filler forwarded", longint'(out_data), 32'hF00D_0005);

    // R4: filler with backlog is discarded
    step(1'b1, 1'b1, 32'hF00D_0006, 1'b0);
    check(int'(occupancy) == 1, "R4", "filler not stored with backlog", longint'(occupancy), 1);
    check(int'(drop_count) == 1, "R4", "drop counted", longint'(drop_count), 1);
    // R8: write and pop together keep occupancy
    step(1'b1, 1'b0, 32'hD000_0007, 1'b1);
    check(int'(occupancy) == 1, "R8", "write+pop same edge", longint'(occupancy), 1);
    idle(2, 1'b1);

    // R7: stall longer than capacity at one flit per 4 cycles
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 32'hB000_0000 + i, 1'b0);
      idle(3, 1'b0);
    end
    check(int'(occupancy) == DEPTH, "R7", "fifo full", longint'(occupancy), DEPTH);
    step(1'b1, 1'b1, 32'hF00D_00FF, 1'b0);
    check(overflow === 1'b0, "R4", "filler at full gives no overflow", longint'(overflow), 0);
    step(1'b1, 1'b0, 32'hBAD0_0000, 1'b1);
    check(overflow === 1'b1, "R7", "overflow set", longint'(overflow), 1);
    check(int'(occupancy) == DEPTH - 1, "R7", "lost flit not stored despite pop",
          longint'(occupancy), DEPTH - 1);
    idle(DEPTH + 2, 1'b1);
    check(overflow === 1'b1, "R7", "overflow sticky after drain", longint'(overflow), 1);
    do_reset();
    check(overflow === 1'b0, "R1", "overflow cleared by reset", longint'(overflow), 0);

    // R6: drop counter saturation
    step(1'b1, 1'b0, 32'hC000_0001, 1'b0);
    for (int i = 0; i < DROP_MAX + 8; i++) step(1'b1, 1'b1, 32'hF00D_0000 + i, 1'b0);
    check(int'(drop_count) == DROP_MAX, "R6", "drop_count saturated", longint'(drop_count), DROP_MAX);
    do_reset();

    // Random segmented traffic with retransmission-like stalls
    begin
      int stall = 0;
      int fidx  = 0;
      for (int t = 0; t < 6000; t++) begin
        bit v, f, acc;
        v = ((t % 4) == 0) && (($urandom % 10) != 0);
        f = 1'b0;
        if (v) begin
          f = ((fidx % 10) >= 8) || (($urandom % 12) == 0);
          fidx++;
        end
        if (stall > 0) begin
          stall--;
          acc = 1'b0;
        end else if (($urandom % 60) == 0) begin
          stall = 30 + ($urandom % 20);
          acc = 1'b0;
        end else begin
          acc = ($urandom % 10) != 0;
        end
        step(v, f, $urandom, acc);
        if ((t % 2000) == 1999) do_reset();
      end
    end
    idle(DEPTH + 2, 1'b1);
    compare_outputs();
    finish_run();
  end

endmodule